// File: doc/BRIEF.md
# Crypto Core Soft-Reset Sequencer

This block returns an encryption accelerator to its idle condition when software asks for it. A start request in the idle state launches a fixed, handshaked teardown: any DMA transfer in progress is stopped first, then the master control unit receives a one-cycle reset pulse, then four configuration registers are cleared with zero, then every loaded-key valid flag is cleared. A one-cycle done pulse marks the end.

The DMA stop step uses a request/acknowledge handshake. The step is skipped when no DMA is active at start. The wait for an acknowledge has a limit. If the limit is reached, the sequencer sets a sticky flag and continues, so the rest of the teardown always completes. The cleared registers are the cipher mode register, the low and high halves of the 64-bit payload length, and the authentication length. They are written one per cycle, in that fixed order.

States: `ST_IDLE` (waiting), `ST_DMA_HALT` (stop request held), `ST_CTL_RST` (control reset pulse), `ST_REG_WR` (register zeroing), `ST_KEY_CLR` (key flags cleared), `ST_DONE` (done pulse). Transitions:
- IDLE→DMA_HALT on start with DMA active.
- IDLE→CTL_RST on start with DMA inactive.
- DMA_HALT→CTL_RST on acknowledge or timeout.
- CTL_RST→REG_WR always.
- REG_WR→KEY_CLR after the last register.
- KEY_CLR→DONE always.
- DONE→IDLE always.

Top module: `crypto_quiesce_seq`

## Requirements
- R1: After reset, every output is low and the timeout flag is clear.
- R2: When start is sampled in idle with `dma_active_i` high, `dma_stop_req_o` is high from the next cycle. It stays high through the cycle in which `dma_stop_ack_i` is sampled high, and drops in the following cycle.
- R3: When start is sampled in idle with `dma_active_i` low, no stop request is raised and `ctl_rst_o` is high in the very next cycle.
- R4: `ctl_rst_o` is high for exactly one cycle. That cycle directly follows the last cycle of the stop request, or the start cycle when the stop step is skipped.
- R5: In the four cycles right after the control reset, `reg_wr_en_o` is high and `reg_wr_sel_o` is one-hot with `reg_wr_data_o` zero. The select goes through bit 0 (cipher mode), bit 1 (payload length low), bit 2 (payload length high), bit 3 (authentication length), in that order.
- R6: In the cycle after the last register write, every bit of `key_clr_o` is high for exactly one cycle.
- R7: `done_o` is high for exactly one cycle, right after the key clear, and the block is idle afterwards.
- R8: If no acknowledge arrives, the stop request is held for exactly TMO_CYCLES (255) cycles, `dma_tmo_o` is set, and the sequence continues. An acknowledge in the last allowed cycle finishes the step normally without setting the flag.
- R9: `dma_tmo_o` stays set until the next start is accepted, and is cleared then.
- R10: A start request sampled while a sequence runs, including in the done cycle, is ignored.
- R11: In any cycle at most one of the stop request, control reset, register write, key clear and done is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to start the teardown |
| dma_active_i | input | 1 | DMA currently moving data |
| dma_stop_ack_i | input | 1 | DMA confirms it has stopped |
| dma_stop_req_o | output | 1 | Request to the DMA to stop |
| ctl_rst_o | output | 1 | One-cycle reset to the master control unit |
| reg_wr_en_o | output | 1 | Register write strobe |
| reg_wr_sel_o | output | 4 | One-hot register select (order in R5) |
| reg_wr_data_o | output | DATA_W | Write data, always zero |
| key_clr_o | output | NUM_KEYS | Per-slot key valid clear strobes |
| done_o | output | 1 | One-cycle completion pulse |
| dma_tmo_o | output | 1 | Sticky DMA stop timeout flag |

## Verification
A wrong internal state shows at the strobes at once. Each state drives exactly one distinct output pattern, so a skipped, repeated or reordered state appears in the per-cycle event stream in the same cycle it happens. A stuck or wrong timeout counter shows only at the end of the stop step: the request lasts the wrong number of cycles, or the flag is wrong. Testing the acknowledge in the last allowed cycle, and the case with no acknowledge at all, exposes an off-by-one within 255 cycles. A state machine that accepts a start while busy shows up as a second control reset or a second write burst in the cycles after done.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DMA_HALT,
        ST_CTL_RST,
        ST_REG_WR,
        ST_KEY_CLR,
        ST_DONE
    } cq_state_e;

    // Zeroing order of the configuration registers (select bit index).
    localparam int unsigned CQ_REG_MODE     = 0;
    localparam int unsigned CQ_REG_LEN_LO   = 1;
    localparam int unsigned CQ_REG_LEN_HI   = 2;
    localparam int unsigned CQ_REG_AUTH_LEN = 3;
    localparam int unsigned CQ_NUM_REGS     = 4;

endpackage

// File: rtl/cq_ack_timer.sv
`timescale 1ns/1ps
// Counts cycles spent waiting for the DMA stop acknowledge.
module cq_ack_timer #(
    parameter int unsigned TMO_CYCLES = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/cq_reg_walker.sv
`timescale 1ns/1ps
// Steps through the register list, one register per cycle.
module cq_reg_walker #(
    parameter int unsigned NUM_REGS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    output logic [NUM_REGS-1:0] sel_o,
    output logic                last_o
);
    localparam int unsigned IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_REGS - 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (!step_i || idx_q == LAST_IDX) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel_o[g] = step_i && (idx_q == IW'(g));
    end

    assign last_o = step_i && (idx_q == LAST_IDX);

endmodule

// File: rtl/cq_ctrl.sv
`timescale 1ns/1ps
// Teardown state machine and sticky timeout flag.
module cq_ctrl
    import cq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      dma_active_i,
    input  logic      dma_ack_i,
    input  logic      expire_i,
    input  logic      wr_last_i,
    output cq_state_e state_o,
    output logic      tmo_flag_o
);
    cq_state_e state_q, state_d;
    logic      accept;
    logic      timed_out;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign timed_out = (state_q == ST_DMA_HALT) && !dma_ack_i && expire_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = dma_active_i ? ST_DMA_HALT : ST_CTL_RST;
                end
            end
            ST_DMA_HALT: begin
                if (dma_ack_i || expire_i) begin
                    state_d = ST_CTL_RST;
                end
            end
            ST_CTL_RST: state_d = ST_REG_WR;
            ST_REG_WR: begin
                if (wr_last_i) begin
                    state_d = ST_KEY_CLR;
                end
            end
            ST_KEY_CLR: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_flag_o <= 1'b0;
        end else if (accept) begin
            tmo_flag_o <= 1'b0;
        end else if (timed_out) begin
            tmo_flag_o <= 1'b1;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/crypto_quiesce_seq.sv
`timescale 1ns/1ps
module crypto_quiesce_seq
    import cq_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_KEYS   = 8,
    parameter int unsigned TMO_CYCLES = 255
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   dma_active_i,
    input  logic                   dma_stop_ack_i,
    output logic                   dma_stop_req_o,
    output logic                   ctl_rst_o,
    output logic                   reg_wr_en_o,
    output logic [CQ_NUM_REGS-1:0] reg_wr_sel_o,
    output logic [DATA_W-1:0]      reg_wr_data_o,
    output logic [NUM_KEYS-1:0]    key_clr_o,
    output logic                   done_o,
    output logic                   dma_tmo_o
);
    cq_state_e              state;
    logic                   expire;
    logic                   wr_last;
    logic [CQ_NUM_REGS-1:0] walk_sel;

    cq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .dma_active_i (dma_active_i),
        .dma_ack_i    (dma_stop_ack_i),
        .expire_i     (expire),
        .wr_last_i    (wr_last),
        .state_o      (state),
        .tmo_flag_o   (dma_tmo_o)
    );

    cq_ack_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state == ST_DMA_HALT),
        .expire_o (expire)
    );

    cq_reg_walker #(.NUM_REGS(CQ_NUM_REGS)) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (state == ST_REG_WR),
        .sel_o  (walk_sel),
        .last_o (wr_last)
    );

    // Moore outputs: one distinct pattern per state.
    always_comb begin
        dma_stop_req_o = 1'b0;
        ctl_rst_o      = 1'b0;
        reg_wr_en_o    = 1'b0;
        reg_wr_sel_o   = '0;
        key_clr_o      = '0;
        done_o         = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_DMA_HALT: dma_stop_req_o = 1'b1;
            ST_CTL_RST:  ctl_rst_o = 1'b1;
            ST_REG_WR: begin
                reg_wr_en_o  = 1'b1;
                reg_wr_sel_o = walk_sel;
            end
            ST_KEY_CLR:  key_clr_o = '1;
            ST_DONE:     done_o = 1'b1;
            default:     ;
        endcase
    end

    assign reg_wr_data_o = '0;

endmodule

// File: rtl/cq_checker.sv
`timescale 1ns/1ps
module cq_checker #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_KEYS = 8,
    parameter int unsigned NUM_REGS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                dma_active_i,
    input logic                dma_stop_req_o,
    input logic                ctl_rst_o,
    input logic                reg_wr_en_o,
    input logic [NUM_REGS-1:0] reg_wr_sel_o,
    input logic [DATA_W-1:0]   reg_wr_data_o,
    input logic [NUM_KEYS-1:0] key_clr_o,
    input logic                done_o,
    input logic                dma_tmo_o
);
    // R3: a stop request only begins from a start seen with DMA active
    a_r3_req_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_stop_req_o) |-> ($past(start_i) && $past(dma_active_i)));

    // R4: control reset follows the stop step or a start without DMA
    a_r4_ctl_order: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_o |-> ($past(dma_stop_req_o) || ($past(start_i) && !$past(dma_active_i))));

    a_r4_ctl_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_o |=> !ctl_rst_o);

    // R5: first write right after the control reset, one-hot, zero data
    a_r5_first_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_rst_o) |-> (reg_wr_en_o && reg_wr_sel_o[0]));

    a_r5_sel_shape: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en_o |-> ($countones(reg_wr_sel_o) == 1 && reg_wr_data_o == '0));

    // R6: key clear is all slots, right after the last write
    a_r6_key_all: assert property (@(posedge clk) disable iff (!rst_n)
        (key_clr_o != '0) |-> ($countones(key_clr_o) == NUM_KEYS
                               && $past(reg_wr_en_o && reg_wr_sel_o[NUM_REGS-1])));

    // R7: done is a single pulse after the key clear
    a_r7_done_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(key_clr_o) != '0));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: timeout flag rises only as the stop request ends
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_tmo_o) |-> ($past(dma_stop_req_o) && !dma_stop_req_o));

    // R9: flag clears only on a start
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_tmo_o) |-> $past(start_i));

    // R11: at most one action per cycle
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dma_stop_req_o, ctl_rst_o, reg_wr_en_o, |key_clr_o, done_o}) <= 1);

endmodule

bind crypto_quiesce_seq cq_checker #(
    .DATA_W   (DATA_W),
    .NUM_KEYS (NUM_KEYS),
    .NUM_REGS (cq_pkg::CQ_NUM_REGS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .dma_active_i   (dma_active_i),
    .dma_stop_req_o (dma_stop_req_o),
    .ctl_rst_o      (ctl_rst_o),
    .reg_wr_en_o    (reg_wr_en_o),
    .reg_wr_sel_o   (reg_wr_sel_o),
    .reg_wr_data_o  (reg_wr_data_o),
    .key_clr_o      (key_clr_o),
    .done_o         (done_o),
    .dma_tmo_o      (dma_tmo_o)
);

// File: tb/crypto_quiesce_seq_test.sv
`timescale 1ns/1ps
module crypto_quiesce_seq_test;
    localparam int DATA_W = 32;
    localparam int NKEYS  = 8;
    localparam int TMO    = 255;
    localparam int NREGS  = 4;

    // event codes seen at the ports each cycle
    localparam int EV_NONE = 0, EV_REQ = 1, EV_CTL = 2, EV_KEY = 4, EV_DONE = 5, EV_WR0 = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dma_active = 1'b0;
    logic ack;
    logic req, ctl, wr_en, done, tmo;
    logic [NREGS-1:0]  wr_sel;
    logic [DATA_W-1:0] wr_data;
    logic [NKEYS-1:0]  key_clr;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // DMA stub: acknowledges after ack_dly cycles of request
    bit stub_en = 1'b0;
    int ack_dly = 0;
    int req_cnt = 0;
    always @(posedge clk) req_cnt <= req ? req_cnt + 1 : 0;
    assign ack = stub_en && req && (req_cnt >= ack_dly);

    crypto_quiesce_seq #(.DATA_W(DATA_W), .NUM_KEYS(NKEYS), .TMO_CYCLES(TMO)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .dma_active_i   (dma_active),
        .dma_stop_ack_i (ack),
        .dma_stop_req_o (req),
        .ctl_rst_o      (ctl),
        .reg_wr_en_o    (wr_en),
        .reg_wr_sel_o   (wr_sel),
        .reg_wr_data_o  (wr_data),
        .key_clr_o      (key_clr),
        .done_o         (done),
        .dma_tmo_o      (tmo)
    );

    typedef struct {
        int    code;
        string tag;
    } exp_t;
    exp_t q[$];

    task automatic push(input int code, input string tag);
        exp_t e;
        e.code = code;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int observe();
        int n;
        n = int'(req) + int'(ctl) + int'(wr_en) + int'(key_clr != '0) + int'(done);
        if (n > 1) return 99;
        if (wr_en && wr_data != '0) return 96;
        if (req) return EV_REQ;
        if (ctl) return EV_CTL;
        if (wr_en) begin
            if ($countones(wr_sel) != 1) return 98;
            for (int i = 0; i < NREGS; i++) if (wr_sel[i]) return EV_WR0 + i;
        end
        if (key_clr != '0) return (key_clr == '1) ? EV_KEY : 97;
        if (done) return EV_DONE;
        return EV_NONE;
    endfunction

    // monitor: compare one expected item per cycle
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(observe(), e.code, e.tag);
        end
    end

    // driver: one teardown, req_cycles of stop request expected
    task automatic run_seq(input bit dma, input int dly, input bit stub, input int req_cycles,
                           input bit hold_start);
        @(posedge clk); #1;
        dma_active = dma;
        ack_dly    = dly;
        stub_en    = stub;
        start      = 1'b1;
        push(EV_NONE, "R1 idle before start");
        for (int i = 0; i < req_cycles; i++) push(EV_REQ, dma ? "R2/R8 stop request" : "R3");
        push(EV_CTL, dma ? "R4 ctl after stop" : "R3 ctl next cycle");
        push(EV_WR0 + 0, "R5 mode write");
        push(EV_WR0 + 1, "R5 len lo write");
        push(EV_WR0 + 2, "R5 len hi write");
        push(EV_WR0 + 3, "R5 auth len write");
        push(EV_KEY, "R6 key clear");
        push(EV_DONE, "R7 done pulse");
        for (int i = 0; i < 3; i++) push(EV_NONE, hold_start ? "R10 start ignored" : "R7 idle after");
        if (hold_start) begin
            repeat (req_cycles + 7) @(posedge clk);
        end
        @(posedge clk); #1;
        start      = 1'b0;
        dma_active = 1'b0;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(req, 0, "R1 req");
        check(ctl, 0, "R1 ctl");
        check(wr_en, 0, "R1 wr_en");
        check(key_clr, 0, "R1 key_clr");
        check(done, 0, "R1 done");
        check(tmo, 0, "R1 tmo");
        rst_n = 1'b1;

        run_seq(1'b0, 0, 1'b0, 0, 1'b0);          // R3: no DMA
        run_seq(1'b1, 0, 1'b1, 1, 1'b0);          // R2: immediate ack
        run_seq(1'b1, 5, 1'b1, 6, 1'b1);          // R2 + R10: start held throughout
        check(tmo, 0, "R8 no flag after ack");
        run_seq(1'b0, 0, 1'b0, 0, 1'b1);          // R10: start held into done cycle

        run_seq(1'b1, 0, 1'b0, TMO, 1'b0);        // R8: no ack, timeout
        check(tmo, 1, "R8 flag set on timeout");
        repeat (10) @(negedge clk);
        check(tmo, 1, "R9 flag sticky while idle");

        run_seq(1'b1, TMO - 1, 1'b1, TMO, 1'b0);  // R8 boundary: ack in last cycle
        check(tmo, 0, "R9 flag cleared by start; R8 no timeout at boundary");

        run_seq(1'b1, 0, 1'b0, TMO, 1'b0);        // timeout again
        check(tmo, 1, "R8 flag set again");
        run_seq(1'b0, 0, 1'b0, 0, 1'b0);
        check(tmo, 0, "R9 flag cleared by start without DMA");

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule